// File: doc/BRIEF.md
# Supply Voltage Detector Sampling Controller

This block decides when an external supply-voltage comparator is powered, and it stores the 4-bit level code that the comparator reports. Time is measured in clock-enable ticks taken from a slow oscillator. A sampling window lasts `WIN_TICKS` ticks. The comparator enable is high for the whole window, and the level input is captured on the last tick of the window.

Software controls the block through one 8-bit register with a byte-wide write port. The register offers two modes:
- A continuous mode, which runs windows back to back.
- An automatic mode, which runs one window every `PERIOD_TICKS` ticks.

When the register is read, bit 4 shows the live busy status rather than the value last written to it. After reset the hardware runs one sample on its own, and the status reads busy until that sample completes. A sleep pulse turns off both modes. A window that is already in progress still runs to its end.

Top module: `svdet_seq`

## Requirements
- R1: While reset is high, and on the cycle after it falls, `cmp_en` is 0. Read bits 5 (auto mode) and 7..6 read 0 out of reset.
- R2: After reset falls, one sampling window starts on the next clock without any write. Read bit 4 (status) is 1 until that window ends and 0 after it.
- R3: `cmp_en` is high for exactly `WIN_TICKS` ticks per window.
- R4: The value on `level_in` at the last tick of a window appears in read bits 3..0, two clocks after `cmp_en` falls.
- R5: Between windows the read level field does not change, whatever `level_in` does.
- R6: Writing 1 to bit 4 starts continuous mode. `cmp_en` then stays high across consecutive windows, and the level field updates at the end of every window.
- R7: Writing 0 to bit 4 in the middle of a window lets that window finish its full length before `cmp_en` falls and the status reads 0.
- R8: Writing 1 to bit 5 makes windows start every `PERIOD_TICKS` ticks. Bit 5 reads back as 1.
- R9: In auto mode, read bit 4 is 1 during a window and 0 between windows.
- R10: With both modes on, `cmp_en` never drops. An auto period that expires during a continuous window does not break or restart it.
- R11: A `sleep_in` pulse clears both mode bits. The window in progress still finishes, and no further window starts.
- R12: Read bits 7 and 6 always read 0, even after writing ones to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable for the slow timebase |
| sleep_in | input | 1 | One-cycle pulse: sleep entry, clears both modes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 5 auto mode, bit 4 continuous mode |
| rd_data | output | 8 | Register value: 0, 0, auto, status, level[3:0] |
| level_in | input | 4 | Level code from the comparator |
| cmp_en | output | 1 | Comparator enable, high during a sampling window |

## Verification
Faults in the window counter show up at the ports as a `cmp_en` pulse with the wrong tick count. Faults in the auto timer show up as the wrong number of ticks between two `cmp_en` rises. Both are visible within one window or one period. A stuck or mis-wired level register shows up at read bits 3..0 two clocks after the window closes, or as drift while the block is idle. A mode register that fails to clear on sleep, or a window that stops early on a mode clear, shows up as an extra window or a short pulse within one period.

// File: rtl/svdet_pkg.sv
package svdet_pkg;
  localparam int LVL_W    = 4;
  localparam int BIT_STAT = 4;
  localparam int BIT_AUTO = 5;
  typedef enum logic {W_IDLE = 1'b0, W_RUN = 1'b1} win_state_t;
endpackage

// File: rtl/svdet_timer.sv
module svdet_timer #(
  parameter int PERIOD_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic fire
);
  localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign fire = run && tick && (cnt == LAST);

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R8
endmodule

// File: rtl/svdet_window.sv
module svdet_window
  import svdet_pkg::*;
#(
  parameter int WIN_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cont_req,
  input  logic             auto_fire,
  input  logic [LVL_W-1:0] level_in,
  output logic             active,
  output logic [LVL_W-1:0] level_q
);
  localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  win_state_t    st;
  logic [CW-1:0] cnt;
  logic          boot_pend;
  logic          start_req;

  assign start_req = boot_pend || cont_req || auto_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      cnt       <= '0;
      boot_pend <= 1'b1;
      level_q   <= '0;
    end else if (st == W_IDLE) begin
      if (start_req) begin
        st        <= W_RUN;
        cnt       <= '0;
        boot_pend <= 1'b0;
      end
    end else if (tick) begin
      if (cnt == LAST) begin
        level_q <= level_in;
        cnt     <= '0;
        st      <= cont_req ? W_RUN : W_IDLE;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign active = (st == W_RUN);

  AST_BOOT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> active); // R2
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= LAST)); // R3
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> $stable(level_q)); // R5
endmodule

// File: rtl/svdet_seq.sv
module svdet_seq
  import svdet_pkg::*;
#(
  parameter int WIN_TICKS    = 5,
  parameter int PERIOD_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sleep_in,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [LVL_W-1:0] level_in,
  output logic             cmp_en
);
  logic             cont_q;
  logic             auto_q;
  logic             auto_fire;
  logic             active;
  logic [LVL_W-1:0] level_q;
  logic             unused_wr;

  assign unused_wr = ^{wr_data[7:6], wr_data[3:0]};

  always_ff @(posedge clk) begin
    if (rst || sleep_in) begin
      cont_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr_en) begin
      cont_q <= wr_data[BIT_STAT];
      auto_q <= wr_data[BIT_AUTO];
    end
  end

  svdet_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .run  (auto_q),
    .fire (auto_fire)
  );

  svdet_window #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cont_req  (cont_q),
    .auto_fire (auto_fire),
    .level_in  (level_in),
    .active    (active),
    .level_q   (level_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= {2'b00, auto_q, active, level_q};
    end
  end

  assign cmp_en = active;

  AST_CONT_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(cmp_en) |-> !$past(cont_q)); // R6
  AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sleep_in ##1 !wr_en |=> !rd_data[BIT_AUTO]); // R11
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |=> (rd_data[7:6] == 2'b00)); // R12
endmodule

// File: tb/svdet_seq_test.sv
module svdet_seq_test;
  localparam int WIN = 5;
  localparam int PER = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       sleep_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] level_in = 4'hA;
  logic       cmp_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [1:0] div = '0;

  svdet_seq #(.WIN_TICKS(WIN), .PERIOD_TICKS(PER)) uut (
    .clk(clk), .rst(rst), .tick(tick), .sleep_in(sleep_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .level_in(level_in), .cmp_en(cmp_en)
  );

  always #4ns clk = ~clk;

  always @(posedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd2);
    cyc  <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_rise(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cmp_en) begin seen = 1'b1; break; end
    end
  endtask

  // counts ticks while cmp_en stays high, returns at fall
  task automatic count_window(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      if (!cmp_en) break;
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_boot();
    int n;
    @(negedge clk);
    rst = 1'b1;
    level_in = 4'hA;
    cyc_wait(4);
    chk(rd_data == 8'h00 && !cmp_en, "R1 reset state", {cmp_en, rd_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmp_en == 1'b1, "R2 boot window start", cmp_en, 1);
    @(negedge clk);
    chk(rd_data[4] == 1'b1, "R2 busy during boot", rd_data[4], 1);
    chk(rd_data[7:5] == 3'b000, "R1 mode bits clear", rd_data[7:5], 0);
    count_window(n);
    chk(n == WIN, "R3 window length", n, WIN);
    cyc_wait(2);
    chk(rd_data == 8'h0A, "R4 boot level, R2 ready", rd_data, 8'h0A);
  endtask

  task automatic t_hold();
    level_in = 4'h3;
    cyc_wait(40);
    chk(rd_data[3:0] == 4'hA && !cmp_en, "R5 level hold while idle", rd_data, 8'h0A);
  endtask

  task automatic t_cont();
    logic seen;
    int n;
    logic dropped;
    logic cleared;
    level_in = 4'h5;
    reg_write(8'h10);
    wait_rise(seen);
    chk(seen, "R6 continuous start", seen, 1);
    n = 0; dropped = 0; cleared = 0;
    for (int i = 0; i < 5000; i++) begin
      if (!cmp_en) break;
      if (tick) begin
        n++;
        if (n == 7) begin
          chk(rd_data[3:0] == 4'h5 && rd_data[4], "R6 level after first window", rd_data, 8'h15);
          level_in = 4'h9;
        end
      end
      if (n == 12 && !cleared) begin
        cleared = 1;
        wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(n == 3 * WIN, "R7 window completes after clear", n, 3 * WIN);
    chk(n >= 12, "R6 back-to-back windows", n, 12);
    cyc_wait(2);
    chk(rd_data == 8'h09, "R7 ready with last level", rd_data, 8'h09);
    cyc_wait(30);
    chk(!cmp_en, "R7 no further window", cmp_en, 0);
  endtask

  task automatic t_auto();
    logic seen;
    int n;
    logic prev;
    level_in = 4'h6;
    reg_write(8'h20);
    @(negedge clk);
    chk(rd_data[5] == 1'b1, "R8 auto bit readback", rd_data[5], 1);
    chk(rd_data[4] == 1'b0 && !cmp_en, "R9 idle before first auto window", rd_data[4], 0);
    wait_rise(seen);
    chk(seen, "R8 auto window start", seen, 1);
    n = 0; prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (cmp_en && !prev) break;
      if (i == 3) chk(rd_data[4] == 1'b1, "R9 busy during auto window", rd_data[4], 1);
      if (i == 40) chk(rd_data[4] == 1'b0 && rd_data[3:0] == 4'h6, "R9 ready between auto windows", rd_data, 8'h26);
      if (tick) n++;
      prev = cmp_en;
    end
    chk(n == PER, "R8 auto period", n, PER);
    count_window(n);
    reg_write(8'h00);
    cyc_wait(4);
  endtask

  task automatic t_both();
    logic seen;
    logic dropped;
    reg_write(8'h30);
    wait_rise(seen);
    dropped = 0;
    for (int i = 0; i < 4 * PER * 4; i++) begin
      @(negedge clk);
      if (!cmp_en) dropped = 1;
    end
    chk(seen && !dropped, "R10 both modes keep window continuous", dropped, 0);
  endtask

  task automatic t_sleep();
    int n;
    logic extra;
    @(negedge clk);
    sleep_in = 1'b1;
    @(negedge clk);
    sleep_in = 1'b0;
    @(negedge clk);
    chk(rd_data[5] == 1'b0, "R11 auto cleared by sleep", rd_data[5], 0);
    count_window(n);
    chk(n <= WIN, "R11 window finishes after sleep", n, WIN);
    extra = 0;
    for (int i = 0; i < 2 * PER * 4; i++) begin
      @(negedge clk);
      if (cmp_en || rd_data[4]) extra = 1;
    end
    chk(!extra, "R11 no window after sleep", extra, 0);
  endtask

  task automatic t_pad();
    int n;
    reg_write(8'hFF);
    @(negedge clk);
    chk(rd_data[7:6] == 2'b00, "R12 upper bits read zero", rd_data[7:6], 0);
    chk(rd_data[5] == 1'b1, "R8 auto bit set by full write", rd_data[5], 1);
    reg_write(8'hC0);
    count_window(n);
    cyc_wait(2);
    chk(rd_data[7:4] == 4'h0, "R12 upper bits zero when idle", rd_data[7:4], 0);
  endtask

  initial begin
    t_reset_boot();
    t_hold();
    t_cont();
    t_auto();
    t_both();
    t_sleep();
    t_pad();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule